// File: doc/BRIEF.md
# Cascadable Serial Control Word Decoder

This block sits on the serial configuration path of one node in a two-dimensional array of crosspoint switches. It samples a serial control stream on the rising edge of its control clock and looks for a six-bit start pattern. The pattern marks either a configuration write or a configuration readback. After a start pattern the rest of the word is walked through with a bit counter. If the word's row and column address fields both arrive as zero, the node acts on it. For a write it stores the four output codes in a load register. For a readback it overwrites the code field of the passing word with its active configuration.

Every bit is also passed on through two forwarding ports, one toward the next node in the row and one toward the next node in the column, with a fixed delay of seven stages. On the way through, the row port reduces the column address by one and the column port reduces the row address by one. A word addressed to a node further down the chain therefore reaches zero/zero at that node. A separate LOAD input copies the load register into the active configuration, which drives the crosspoint selects.

Top module: `xbar_serial_ctl`

## Requirements
- R1: A word is 30 bits, sent most significant bit first, laid out as [29:24] start pattern, [23:18] row address, [17:12] column address, then the output 1 code in [11:9] down to the output 4 code in [2:0]. Only 011111 (write) and 011110 (readback) start a word. A word with any other start passes through both ports unchanged and stores nothing.
- R2: A write whose row or column address is non-zero leaves the load register unchanged.
- R3: The serial input is sampled on the rising edge of sclk. A bit sampled at edge n is driven on rowOut and colOut from just after edge n+6 until edge n+7, unless R4, R5 or R8 modifies it.
- R4: On rowOut, the column address field of every valid word leaves reduced by one modulo 64 (0 becomes 63). All other fields are unchanged.
- R5: On colOut, the row address field of every valid word leaves reduced by one modulo 64. All other fields are unchanged.
- R6: A write with both addresses zero puts its 12 code bits into the load register. A LOAD sampled high at the second rising edge after the word's final bit places them on cfgOut, with the output 1 code in [11:9] and the output 4 code in [2:0].
- R7: cfgOut changes only at a rising edge where loadIn is sampled high.
- R8: A readback with both addresses zero replaces the 12 code bits of both forwarded words with cfgOut, most significant bit first. It leaves the load register unchanged. The next word is decoded normally, so a following write still loads.
- R9: Search for a start pattern resumes right after a word's final bit, so words sent back to back with no idle bits are each decoded.
- R10: While rstN is low, rowOut, colOut and cfgOut are 0.
- R11: rowClkOut and colClkOut follow sclk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial control clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| serIn | input | 1 | Serial control data |
| loadIn | input | 1 | Copies the load register to the active configuration at a rising edge |
| rowOut | output | 1 | Forwarded data toward the next node in the row |
| rowClkOut | output | 1 | Forwarded clock for rowOut |
| colOut | output | 1 | Forwarded data toward the next node in the column |
| colClkOut | output | 1 | Forwarded clock for colOut |
| cfgOut | output | 12 | Active configuration, four 3-bit output codes |

## Verification
If the bit counter slips against the real word boundary, the decrement lands on the wrong bits. This shows on rowOut or colOut within seven edges of the misplaced field, so comparing every forwarded bit against a model catches it at once. A frame history that fails to recover after a word shows as a back-to-back word passing undecremented. A wrong load register stays hidden until the next LOAD, so LOAD pulses follow each directed case and appear at random points in the random stream. A wrong readback index shows as permuted code bits in the forwarded word.

// File: rtl/xbar_ctl_pkg.sv
package xbar_ctl_pkg;
  parameter int FRAME_W = 6;
  parameter int ADDR_W  = 6;
  parameter int NUM_OUT = 4;
  parameter int CODE_W  = 3;

  localparam int CFG_W  = NUM_OUT * CODE_W;
  localparam int BODY_W = 2 * ADDR_W + CFG_W;
  localparam int CNT_W  = $clog2(BODY_W);
  localparam int IDX_W  = $clog2(CFG_W);

  localparam logic [FRAME_W-1:0] WR_FRAME = 6'b011111;
  localparam logic [FRAME_W-1:0] RD_FRAME = 6'b011110;

  // strobes from the word sequencer to the datapath, valid for the incoming bit
  typedef struct packed {
    logic             decRow;  // incoming bit is the row address LSB
    logic             decCol;  // incoming bit is the column address LSB
    logic             rdSub;   // replace incoming code bit with configuration
    logic [IDX_W-1:0] rdIdx;   // configuration bit to insert
    logic             commit;  // incoming bit completes a matched write
  } stb_t;
endpackage

// File: rtl/xbar_ctl_seq.sv
module xbar_ctl_seq
  import xbar_ctl_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic serIn,
  output stb_t stb
);
  logic               inBody;
  logic [CNT_W-1:0]   bitCnt;
  logic               isRead;
  logic               addrZero;
  logic [FRAME_W-2:0] hist;
  logic [FRAME_W-1:0] window;
  logic               wrHit;
  logic               rdHit;

  always_comb begin
    window = {hist, serIn};
    wrHit  = !inBody && (window == WR_FRAME);
    rdHit  = !inBody && (window == RD_FRAME);
  end

  // bitCnt equals the body index of the bit currently on serIn
  always_comb begin
    stb = '0;
    if (inBody) begin
      stb.decRow = (bitCnt == CNT_W'(ADDR_W - 1));
      stb.decCol = (bitCnt == CNT_W'(2 * ADDR_W - 1));
      if (bitCnt >= CNT_W'(2 * ADDR_W) && addrZero) begin
        stb.rdSub  = isRead;
        stb.rdIdx  = IDX_W'(BODY_W - 1 - int'(bitCnt));
        stb.commit = !isRead && (bitCnt == CNT_W'(BODY_W - 1));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBody   <= 1'b0;
      bitCnt   <= '0;
      isRead   <= 1'b0;
      addrZero <= 1'b0;
      hist     <= '1;
    end else if (!inBody) begin
      hist <= window[FRAME_W-2:0];
      if (wrHit || rdHit) begin
        inBody   <= 1'b1;
        bitCnt   <= '0;
        isRead   <= rdHit;
        addrZero <= 1'b1;
      end
    end else begin
      if (bitCnt < CNT_W'(2 * ADDR_W) && serIn) addrZero <= 1'b0;
      if (bitCnt == CNT_W'(BODY_W - 1)) begin
        inBody <= 1'b0;
        bitCnt <= '0;
        // all ones: no start pattern can match until six fresh bits arrived
        hist   <= '1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xbar_ctl_path.sv
module xbar_ctl_path
  import xbar_ctl_pkg::*;
#(
  parameter int FWD_LAT = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             loadIn,
  input  stb_t             stb,
  output logic             rowOut,
  output logic             colOut,
  output logic [CFG_W-1:0] cfgOut
);
  logic [CFG_W-1:0] recent;
  logic [CFG_W-1:0] loadReg;
  logic [CFG_W-1:0] cfgReg;
  logic             inBit;

  always_comb inBit = stb.rdSub ? cfgReg[stb.rdIdx] : serIn;

  // port 0 forwards along the row (column field reduced),
  // port 1 forwards along the column (row field reduced)
  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [FWD_LAT-1:0] line;
    logic               decHere;
    logic [ADDR_W-1:0]  fieldDec;

    assign decHere  = (p == 0) ? stb.decCol : stb.decRow;
    assign fieldDec = {line[ADDR_W-2:0], inBit} - ADDR_W'(1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        line <= '0;
      else if (decHere) line <= {line[FWD_LAT-2:ADDR_W-1], fieldDec};
      else              line <= {line[FWD_LAT-2:0], inBit};
    end
  end

  assign rowOut = g_port[0].line[FWD_LAT-1];
  assign colOut = g_port[1].line[FWD_LAT-1];
  assign cfgOut = cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recent  <= '0;
      loadReg <= '0;
      cfgReg  <= '0;
    end else begin
      recent <= {recent[CFG_W-2:0], serIn};
      if (stb.commit) loadReg <= {recent[CFG_W-2:0], serIn};
      if (loadIn)     cfgReg  <= loadReg;
    end
  end
endmodule

// File: rtl/xbar_serial_ctl.sv
module xbar_serial_ctl
  import xbar_ctl_pkg::*;
#(
  parameter int FWD_LAT = 7
) (
  input  logic             sclk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             loadIn,
  output logic             rowOut,
  output logic             rowClkOut,
  output logic             colOut,
  output logic             colClkOut,
  output logic [CFG_W-1:0] cfgOut
);
  stb_t ctlStb;

  xbar_ctl_seq i_seq (
    .clk   (sclk),
    .rstN  (rstN),
    .serIn (serIn),
    .stb   (ctlStb)
  );

  xbar_ctl_path #(.FWD_LAT(FWD_LAT)) i_path (
    .clk    (sclk),
    .rstN   (rstN),
    .serIn  (serIn),
    .loadIn (loadIn),
    .stb    (ctlStb),
    .rowOut (rowOut),
    .colOut (colOut),
    .cfgOut (cfgOut)
  );

  assign rowClkOut = sclk;
  assign colClkOut = sclk;
endmodule

// File: rtl/xbar_serial_ctl_chk.sv
module xbar_serial_ctl_chk
  import xbar_ctl_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             serIn,
  input logic             loadIn,
  input logic             rowOut,
  input logic             colOut,
  input logic [CFG_W-1:0] cfgOut,
  input stb_t             stb
);
  logic [3:0] sinceMod;
  logic [3:0] sinceDec;
  logic       rdBit;

  always_comb rdBit = stb.rdSub ? cfgOut[stb.rdIdx] : 1'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceMod <= '0;
      sinceDec <= '0;
    end else begin
      if (stb.decRow || stb.decCol || stb.rdSub) sinceMod <= '0;
      else if (sinceMod != 4'd8)                 sinceMod <= sinceMod + 1'b1;
      if (stb.decRow || stb.decCol)              sinceDec <= '0;
      else if (sinceDec != 4'd8)                 sinceDec <= sinceDec + 1'b1;
    end
  end

  assert_fwd_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceMod >= 4'd7) |-> (rowOut == $past(serIn, 7) && colOut == $past(serIn, 7)));

  // R4 and R5: the two ports differ only inside the decremented address fields
  assert_ports_agree_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sinceDec >= 4'd7) |-> (rowOut == colOut));

  assert_readback_bit_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.rdSub, 7) |-> (rowOut == $past(rdBit, 7) && colOut == $past(rdBit, 7)));

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !loadIn |=> $stable(cfgOut));
endmodule

bind xbar_serial_ctl xbar_serial_ctl_chk i_chk (
  .clk    (sclk),
  .rstN   (rstN),
  .serIn  (serIn),
  .loadIn (loadIn),
  .rowOut (rowOut),
  .colOut (colOut),
  .cfgOut (cfgOut),
  .stb    (ctlStb)
);

// File: tb/test_xbar_serial_ctl.sv
`timescale 1ns/1ps
module test_xbar_serial_ctl;
  localparam logic [5:0] WR = 6'b011111;
  localparam logic [5:0] RD = 6'b011110;
  localparam int MAXB = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0;
  logic loadIn = 1'b0;
  logic rowOut, rowClkOut, colOut, colClkOut;
  logic [11:0] cfgOut;

  always #2 clk = ~clk;

  xbar_serial_ctl i_xbar_serial_ctl (
    .sclk(clk), .rstN(rstN), .serIn(serIn), .loadIn(loadIn),
    .rowOut(rowOut), .rowClkOut(rowClkOut), .colOut(colOut),
    .colClkOut(colClkOut), .cfgOut(cfgOut)
  );

  bit          inS  [MAXB];
  bit          eRow [MAXB];
  bit          eCol [MAXB];
  bit          ld   [MAXB];
  string       tRow [MAXB];
  string       tCol [MAXB];
  string       tCfg [MAXB];
  logic [11:0] eCfg [MAXB];
  int          len = 0;
  logic [11:0] mCfg = '0;
  logic [11:0] mLoad = '0;
  int          nChk = 0;
  int          nErr = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // idle zeros; optional LOAD at the second edge after the previous word's last bit
  task automatic appendGap(input int n, input bit doLoad, input string ldTag);
    for (int i = 0; i < n; i++) begin
      ld[len] = doLoad && (i == 1);
      tCfg[len] = "R7";
      if (ld[len]) begin
        mCfg = mLoad;
        tCfg[len] = ldTag;
      end
      inS[len] = 1'b0; eRow[len] = 1'b0; eCol[len] = 1'b0;
      tRow[len] = "R3"; tCol[len] = "R3";
      eCfg[len] = mCfg;
      len++;
    end
  endtask

  task automatic appendWord(input logic [5:0] fr, input logic [5:0] rw, input logic [5:0] cl,
                            input logic [11:0] cd, input string passTag);
    logic [29:0] w, wr, wc;
    logic [11:0] cx;
    bit valid, rd, hit;
    valid = (fr == WR) || (fr == RD);
    rd    = (fr == RD);
    hit   = (rw == 6'd0) && (cl == 6'd0);
    cx    = (valid && rd && hit) ? mCfg : cd;
    w     = {fr, rw, cl, cd};
    if (valid) begin
      wr = {fr, rw, cl - 6'd1, cx};
      wc = {fr, rw - 6'd1, cl, cx};
    end else begin
      wr = w;
      wc = w;
    end
    for (int i = 29; i >= 0; i--) begin
      string tr, tc;
      tr = passTag; tc = passTag;
      if (!valid) begin
        tr = "R1"; tc = "R1";
      end else begin
        if (i >= 12 && i <= 17) tr = "R4";
        if (i >= 18 && i <= 23) tc = "R5";
        if (i < 12 && rd && hit) begin tr = "R8"; tc = "R8"; end
      end
      inS[len] = w[i]; eRow[len] = wr[i]; eCol[len] = wc[i];
      tRow[len] = tr; tCol[len] = tc;
      ld[len] = 1'b0; eCfg[len] = mCfg; tCfg[len] = "R7";
      len++;
    end
    if (valid && !rd && hit) mLoad = cd;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nErr++; nChk++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nErr);
    $finish;
  end

  initial begin
    int prevGap;
    void'($urandom(32'd20240611));

    // directed corner cases
    appendGap(3, 1'b0, "R7");
    appendWord(WR, 6'd0, 6'd0, 12'b001010011100, "R3");      // matched write
    appendGap(3, 1'b1, "R6");
    appendWord(WR, 6'd0, 6'd1, 12'b100100100100, "R3");      // column miss, 1 -> 0
    appendGap(2, 1'b0, "R7");
    appendWord(WR, 6'd1, 6'd0, 12'b011011011011, "R3");      // row miss
    appendGap(3, 1'b1, "R2");
    appendWord(RD, 6'd0, 6'd0, 12'b000000000000, "R3");      // matched readback
    appendGap(2, 1'b0, "R7");
    appendWord(RD, 6'd3, 6'd0, 12'b010011001000, "R3");      // readback miss
    appendGap(2, 1'b0, "R7");
    appendWord(6'b011101, 6'd0, 6'd0, 12'b001001001001, "R1"); // bad start pattern
    appendGap(3, 1'b1, "R1");
    appendWord(RD, 6'd0, 6'd0, 12'b000000000000, "R3");
    appendWord(WR, 6'd0, 6'd0, 12'b011001000010, "R9");      // back to back after a read
    appendGap(3, 1'b1, "R8");

    // constrained random stream
    prevGap = 3;
    for (int k = 0; k < 40; k++) begin
      logic [5:0] fr, rw, cl;
      logic [11:0] cd;
      int g;
      fr = ($urandom % 2 == 0) ? WR : RD;
      case ($urandom % 4)
        0: rw = 6'd0; 1: rw = 6'd1; 2: rw = 6'd0; default: rw = 6'($urandom);
      endcase
      case ($urandom % 4)
        0: cl = 6'd0; 1: cl = 6'd1; 2: cl = 6'd0; default: cl = 6'($urandom);
      endcase
      for (int j = 0; j < 4; j++) cd[j*3 +: 3] = 3'($urandom % 5);
      appendWord(fr, rw, cl, cd, (prevGap == 0) ? "R9" : "R3");
      g = $urandom % 5;
      appendGap(g, (g >= 2) && ($urandom % 2 == 1), "R6");
      prevGap = g;
    end
    appendGap(3, 1'b1, "R6");

    // reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "rowOut in reset", int'(rowOut), 0);
    chk("R10", "colOut in reset", int'(colOut), 0);
    chk("R10", "cfgOut in reset", int'(cfgOut), 0);
    rstN = 1'b1;

    for (int c = 0; c < len + 8; c++) begin
      @(negedge clk);
      if (c >= 7 && c - 7 < len) begin
        chk(tRow[c-7], $sformatf("rowOut bit %0d", c - 7), int'(rowOut), int'(eRow[c-7]));
        chk(tCol[c-7], $sformatf("colOut bit %0d", c - 7), int'(colOut), int'(eCol[c-7]));
      end
      if (c >= 1 && c - 1 < len)
        chk(tCfg[c-1], $sformatf("cfgOut after edge %0d", c - 1), int'(cfgOut), int'(eCfg[c-1]));
      serIn  = (c < len) ? inS[c] : 1'b0;
      loadIn = (c < len) ? ld[c] : 1'b0;
    end

    // forwarded clocks
    @(posedge clk); #1;
    chk("R11", "rowClkOut high", int'(rowClkOut), 1);
    chk("R11", "colClkOut high", int'(colClkOut), 1);
    @(negedge clk); #1;
    chk("R11", "rowClkOut low", int'(rowClkOut), 0);
    chk("R11", "colClkOut low", int'(colClkOut), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nErr);
    $finish;
  end
endmodule